// File: doc/BRIEF.md
# Converter Sample Octet Framer-Scrambler

This block turns a stream of 14-bit converter samples into a stream of octets for a downstream 8b/10b encoder. Each accepted sample becomes one frame of two octets. The first octet carries the sample's upper eight bits. The second octet carries its lower six bits followed by two tail bits. The upper tail bit can be set to report an out-of-range flag for that sample. After packing, the octets can be passed through a self-synchronizing scrambler with the polynomial 1 + x^14 + x^15.

The block emits one octet per clock while a frame is in flight. A valid strobe and a frame-start marker go with each octet. A sample is taken through a valid/ready pair, and ready is high at most every second cycle. Two configuration inputs control the block. One switches scrambling on or off, checked again on every octet. The other decides whether the upper tail bit carries the out-of-range flag, checked once per sample.

Top module: `octet_framer_scrambler`

## Requirements
- R1: After reset, `oct_valid` and `oct_first` are 0 and `smp_ready` is 1.
- R2: A sample is accepted on a rising edge where `smp_valid` and `smp_ready` are both 1. `smp_ready` is 0 in the following cycle, and a sample offered during that cycle is ignored.
- R3: The first octet of a frame appears one edge after acceptance. Before scrambling it equals sample bits 13..6, with bit 13 in octet bit 7.
- R4: The second octet appears on the edge after the first. Before scrambling, its bits 7..2 hold sample bits 5..0 and its bits 1..0 hold the tail.
- R5: The tail is taken when the sample is accepted. If `cfg_ovr_tail` is 1 at that point, the tail is {smp_ovr, 0}. Otherwise the tail is 00.
- R6: `oct_first` is 1 with the first octet of each frame and 0 with the second. `oct_valid` is 1 for exactly those two cycles unless a new sample follows at once. If `smp_valid` is held high, frames follow each other with no gap.
- R7: With scrambling on, octets are scrambled bit-serially, MSB first. Each output bit equals the input bit XOR the scrambled output bits from 14 and 15 bit positions earlier.
- R8: The 15-bit scrambler history is all ones after reset. It continues across octet and frame boundaries and is never cleared between frames.
- R9: With scrambling off, octets come out unchanged and the history is frozen. When scrambling is turned back on, it resumes from the frozen history.
- R10: `cfg_scr_en` is checked separately for each octet, when that octet is formed. A change between the two octets of a frame therefore affects only the second octet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is offered |
| smp_ready | output | 1 | The block can take a sample this cycle |
| smp_data | input | 14 | Converter sample |
| smp_ovr | input | 1 | Out-of-range flag for the sample |
| cfg_scr_en | input | 1 | Scrambling on (1) or off (0) |
| cfg_ovr_tail | input | 1 | Upper tail bit carries the out-of-range flag |
| oct_valid | output | 1 | `oct_data` holds an octet |
| oct_first | output | 1 | The octet is the first of its frame |
| oct_data | output | 8 | Output octet |

## Verification
The first octet is due one rising edge after the acceptance edge, and the second octet one edge after that. The bench drives its inputs on falling edges. It samples at the falling edge after the acceptance edge for the first octet and one clock later for the second, so each result is read half a cycle after the register that produces it has loaded. The bench keeps its own model of the scrambler history, advanced one bit at a time. Its expected octets therefore follow every change of `cfg_scr_en` between octets and frames, including the changes made in the middle of a frame.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int SMP_W    = 14;
  localparam int OCT_W    = 8;
  localparam int TAIL_W   = 2 * OCT_W - SMP_W;
  localparam int LO_W     = SMP_W - OCT_W;
  localparam int TAP_NEAR = 14;
  localparam int TAP_FAR  = 15;
  localparam int HIST_W   = TAP_FAR;

  typedef struct packed {
    logic [HIST_W-1:0] hist;
    logic [OCT_W-1:0]  oct;
  } scr_res_t;

  // Bit-serial scramble of one octet, MSB first; hist[0] is the newest output bit.
  function automatic scr_res_t scr_octet(input logic [HIST_W-1:0] hist_in,
                                         input logic [OCT_W-1:0] din);
    scr_res_t r;
    logic [HIST_W-1:0] h;
    logic b;
    h = hist_in;
    r.oct = '0;
    for (int i = OCT_W - 1; i >= 0; i--) begin
      b = din[i] ^ h[TAP_NEAR-1] ^ h[TAP_FAR-1];
      r.oct[i] = b;
      h = {h[HIST_W-2:0], b};
    end
    r.hist = h;
    return r;
  endfunction

  function automatic logic [TAIL_W-1:0] make_tail(input logic ovr, input logic use_ovr);
    logic [TAIL_W-1:0] t;
    t = '0;
    if (use_ovr) t[TAIL_W-1] = ovr;
    return t;
  endfunction
endpackage

// File: rtl/ofs_packer.sv
module ofs_packer
  import ofs_pkg::*;
(
  input  logic [SMP_W-1:0] sample,
  input  logic             ovr,
  input  logic             use_ovr,
  output logic [OCT_W-1:0] oct_hi,
  output logic [OCT_W-1:0] oct_lo
);
  logic [TAIL_W-1:0] tail;

  always_comb begin
    tail   = make_tail(ovr, use_ovr);
    oct_hi = sample[SMP_W-1 -: OCT_W];
    oct_lo = {sample[LO_W-1:0], tail};
  end
endmodule

// File: rtl/ofs_scrambler.sv
module ofs_scrambler
  import ofs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             en,
  input  logic [OCT_W-1:0] din,
  output logic [OCT_W-1:0] dout
);
  logic [HIST_W-1:0] hist_q;
  scr_res_t          res;
  logic              advance;

  always_comb begin
    res     = scr_octet(hist_q, din);
    advance = step && en;
    dout    = en ? res.oct : din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hist_q <= '1;
    else if (advance) hist_q <= res.hist;
  end

  // R9: history frozen while scrambling is off
  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !en) |=> $stable(hist_q));
  // R8: history idles unchanged between octets
  assert_hist_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(hist_q));
endmodule

// File: rtl/octet_framer_scrambler.sv
module octet_framer_scrambler
  import ofs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [13:0]      smp_data,
  input  logic             smp_ovr,
  input  logic             cfg_scr_en,
  input  logic             cfg_ovr_tail,
  output logic             oct_valid,
  output logic             oct_first,
  output logic [7:0]       oct_data
);
  logic             phase_q;
  logic [OCT_W-1:0] lo_q;
  logic [OCT_W-1:0] hi_w, lo_w, raw_w, scr_w;
  logic             accept, emit;

  assign smp_ready = !phase_q;
  assign accept    = smp_valid && smp_ready;
  assign emit      = accept || phase_q;
  assign raw_w     = phase_q ? lo_q : hi_w;

  ofs_packer u_pack (
    .sample (smp_data),
    .ovr    (smp_ovr),
    .use_ovr(cfg_ovr_tail),
    .oct_hi (hi_w),
    .oct_lo (lo_w)
  );

  ofs_scrambler u_scr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (emit),
    .en   (cfg_scr_en),
    .din  (raw_w),
    .dout (scr_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      lo_q      <= '0;
      oct_valid <= 1'b0;
      oct_first <= 1'b0;
      oct_data  <= '0;
    end else begin
      phase_q   <= accept;
      oct_valid <= emit;
      oct_first <= accept;
      if (accept) lo_q <= lo_w;
      if (emit)   oct_data <= scr_w;
    end
  end

  // R2: ready drops for the cycle after an acceptance
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !smp_ready);
  // R6: first octet follows acceptance with the frame marker
  assert_first_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (oct_valid && oct_first));
  // R6: second octet always follows the first
  assert_second_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_valid && oct_first) |=> (oct_valid && !oct_first));
  // R3: unscrambled first octet carries the sample's upper bits
  assert_passthru_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_scr_en) |=> (oct_data == $past(smp_data[13:6])));
  // R1: no octet without a preceding acceptance or open frame
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && smp_ready) |=> !oct_valid);
endmodule

// File: tb/octet_framer_scrambler_bench.sv
module octet_framer_scrambler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [13:0] smp_data = '0;
  logic smp_ovr = 1'b0;
  logic cfg_scr_en = 1'b0;
  logic cfg_ovr_tail = 1'b0;
  logic oct_valid, oct_first;
  logic [7:0] oct_data;

  int checks = 0;
  int failures = 0;
  logic [14:0] past_bits;  // past_bits[k] = scrambled bit k+1 positions ago

  always #5 clk = ~clk;

  octet_framer_scrambler u_octet_framer_scrambler (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_ovr(smp_ovr), .cfg_scr_en(cfg_scr_en),
    .cfg_ovr_tail(cfg_ovr_tail), .oct_valid(oct_valid), .oct_first(oct_first),
    .oct_data(oct_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_oct(input logic [7:0] d, input bit scr);
    logic [7:0] o;
    logic b;
    if (!scr) return d;
    for (int i = 7; i >= 0; i--) begin
      b = d[i] ^ past_bits[13] ^ past_bits[14];
      o[i] = b;
      past_bits = {past_bits[13:0], b};
    end
    return o;
  endfunction

  // Send one sample; scr_lo is the scramble setting applied for the second octet (R10).
  task automatic send(input logic [13:0] d, input logic ovr, input bit tail_en,
                      input bit scr_hi, input bit scr_lo, input string req);
    logic [7:0] e_hi, e_lo;
    e_hi = d[13:6];
    e_lo = {d[5:0], (tail_en ? ovr : 1'b0), 1'b0};
    smp_data = d; smp_ovr = ovr; cfg_ovr_tail = tail_en; cfg_scr_en = scr_hi;
    smp_valid = 1'b1;
    @(posedge clk); #5;
    smp_valid = 1'b0;
    e_hi = model_oct(e_hi, scr_hi);
    check(oct_valid && oct_first, {req, " R6 first marker"}, {oct_valid, oct_first}, 3);
    check(oct_data == e_hi, {req, " R3 octet0"}, oct_data, e_hi);
    check(!smp_ready, {req, " R2 ready low"}, smp_ready, 0);
    cfg_scr_en = scr_lo;
    cfg_ovr_tail = !tail_en;  // must not affect the tail already captured (R5)
    smp_ovr = !ovr;
    @(posedge clk); #5;
    e_lo = model_oct(e_lo, scr_lo);
    check(oct_valid && !oct_first, {req, " R6 second octet"}, {oct_valid, oct_first}, 2);
    check(oct_data == e_lo, {req, " R4 octet1"}, oct_data, e_lo);
    check(smp_ready, {req, " R2 ready back"}, smp_ready, 1);
  endtask

  task automatic t_reset();
    check(!oct_valid && !oct_first, "R1 outputs idle", {oct_valid, oct_first}, 0);
    check(smp_ready, "R1 ready", smp_ready, 1);
    @(posedge clk); #5;
    check(!oct_valid, "R1 idle without sample", oct_valid, 0);
  endtask

  task automatic t_plain();
    send(14'h3FFF, 1'b0, 0, 0, 0, "plain R3 R4");
    send(14'h2AAA, 1'b1, 0, 0, 0, "plain R5 filler");
    send(14'h0001, 1'b0, 0, 0, 0, "plain lsb");
    send(14'h2000, 1'b1, 0, 0, 0, "plain msb");
  endtask

  task automatic t_tail();
    send(14'h1234, 1'b1, 1, 0, 0, "R5 ovr set");
    send(14'h1234, 1'b0, 1, 0, 0, "R5 ovr clear");
  endtask

  task automatic t_ready();
    logic [7:0] e;
    smp_data = 14'h0ABC; smp_ovr = 1'b0; cfg_ovr_tail = 1'b0; cfg_scr_en = 1'b0;
    smp_valid = 1'b1;
    @(posedge clk); #5;
    check(oct_data == 8'h2A, "R3 b2b first", oct_data, 8'h2A);
    smp_data = 14'h3F00;  // offered while not ready: ignored (R2)
    @(posedge clk); #5;
    e = {6'h3C, 2'b00};
    check(oct_data == e && !oct_first, "R2 ignored sample R4", oct_data, e);
    @(posedge clk); #5;
    smp_valid = 1'b0;
    check(oct_valid && oct_first && oct_data == 8'hFC, "R6 back-to-back frame", oct_data, 8'hFC);
    @(posedge clk); #5;
    check(oct_valid && !oct_first && oct_data == 8'h00, "R6 b2b second", oct_data, 8'h00);
    @(posedge clk); #5;
    check(!oct_valid, "R6 valid drops", oct_valid, 0);
  endtask

  task automatic t_scramble();
    send(14'h0000, 1'b0, 0, 1, 1, "R7 R8 zero from reset hist");
    send(14'h1555, 1'b1, 1, 1, 1, "R7 pattern");
    send(14'h3C3C, 1'b0, 0, 1, 1, "R8 carry across frames");
  endtask

  task automatic t_toggle();
    send(14'h2F0F, 1'b0, 0, 0, 0, "R9 pass-through");
    send(14'h0F0F, 1'b0, 0, 1, 1, "R9 resume from frozen hist");
    send(14'h1111, 1'b1, 1, 1, 0, "R10 off for second octet");
    send(14'h2222, 1'b0, 0, 0, 1, "R10 on for second octet");
  endtask

  initial begin
    past_bits = '1;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    #5;
    t_reset();
    t_plain();
    t_tail();
    t_ready();
    t_scramble();
    t_toggle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule